// File: doc/BRIEF.md
# PLL configuration register bank

This block holds the control word set for a phase-locked loop behind a small memory-mapped register bus. Three 32-bit registers sit at byte offsets 0x0, 0x4 and 0x8. The first two accept per-bit write enables carried in the upper half of the written word, so software can change one field without reading the register first. The third register holds a wide fractional value and is written whole.

The decoded fields drive the PLL model directly: feedback divider, reference divider, two post-dividers, an integer/fractional select, the fractional value and a power-down control. The lock indication from the PLL is brought through a synchronizer and read back as a status bit. Reads are combinational from the address. Writes take effect on the rising clock edge that samples the write strobe.

Top module: `pll_cfg_bank`

## Requirements
- R1: After reset, offset 0x0 reads 0x0000_1001 (feedback divider 1, first post-divider 1), offset 0x4 reads 0x0000_3041 while lock is low (reference divider 1, second post-divider 1, fractional bypass 1, power-down 1), and offset 0x8 reads 0.
- R2: A write to offset 0x0 changes low bit i (i in 0..14) only when bit i+16 of the same write word is 1. Bits [11:0] are the feedback divider and bits [14:12] are the first post-divider.
- R3: A write to offset 0x4 changes low bit i only when bit i+16 is set. The reference divider is bits [5:0], the second post-divider is bits [8:6] and the fractional bypass is bit 12. Bits 9, 11, 14 and 15 read 0.
- R4: Bit 13 of offset 0x4 is power-down: the power_down output follows it, and the PLL is enabled when it is 0.
- R5: Offset 0x8 stores write bits [23:0] directly with no mask, drives frac_val, and reads 0 in bits [31:24].
- R6: Bit 10 of offset 0x4 reads the lock input after LOCK_SYNC_STAGES clock edges, and no write can change it.
- R7: Bits [31:16] of offsets 0x0 and 0x4 store nothing and always read 0.
- R8: A write to any address other than 0x0, 0x4 or 0x8 changes no output and no register. A read of such an address returns 0.
- R9: The field outputs carry the new register contents starting in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data; upper half is the bit-enable mask for offsets 0x0 and 0x4 |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pll_lock | input | 1 | Lock indication from the PLL, asynchronous |
| fb_div | output | 12 | Feedback divider |
| post_div1 | output | 3 | First post-divider |
| ref_div | output | 6 | Reference divider |
| post_div2 | output | 3 | Second post-divider |
| frac_bypass | output | 1 | 1 selects integer mode, 0 fractional mode |
| power_down | output | 1 | 1 powers the PLL down |
| frac_val | output | 24 | Fractional feedback value |

## Verification
The masked write to offset 0x4 and the synchronized lock status share the same register word, so they can meet in one cycle. The bench raises the lock input in the same cycle as a write that enables bit 10 with a 0 in it and also changes the second post-divider and power-down. A correct result shows the new fields, with bit 10 following the lock input and not the written value. A second case writes to offset 0x0 with every enable set, including the upper half, and judges that no upper bit ever reads back.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned NUM_REGS = 3;

  // field widths
  localparam int unsigned FB_W    = 12;
  localparam int unsigned PD_W    = 3;
  localparam int unsigned REF_W   = 6;
  localparam int unsigned FRAC_W  = 24;

  // register 0 positions
  localparam int unsigned FB_LSB  = 0;
  localparam int unsigned PD1_LSB = 12;
  // register 1 positions
  localparam int unsigned REF_LSB = 0;
  localparam int unsigned PD2_LSB = 6;
  localparam int unsigned LOCK_BIT = 10;
  localparam int unsigned BYP_BIT  = 12;
  localparam int unsigned PWR_BIT  = 13;

  // implemented (storable) bits
  localparam logic [HALF_W-1:0] R0_IMPL = 16'h7FFF;
  localparam logic [HALF_W-1:0] R1_IMPL = 16'h31FF;
  localparam logic [FRAC_W-1:0] R2_IMPL = '1;

  // reset contents
  localparam logic [HALF_W-1:0] R0_RST = 16'h1001;
  localparam logic [HALF_W-1:0] R1_RST = 16'h3041;
  localparam logic [FRAC_W-1:0] R2_RST = '0;

  // byte address of register n
  function automatic int unsigned reg_offset(input int unsigned n);
    return 4 * n;
  endfunction

  // bit-enable merge of a half-word register
  function automatic logic [HALF_W-1:0] masked_merge(
      input logic [HALF_W-1:0] old_q,
      input logic [DATA_W-1:0] word,
      input logic [HALF_W-1:0] impl);
    logic [HALF_W-1:0] en;
    en = word[DATA_W-1:HALF_W] & impl;
    return (old_q & ~en) | (word[HALF_W-1:0] & en);
  endfunction

endpackage

// File: rtl/pll_cfg_decode.sv
module pll_cfg_decode #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]                    addr,
  output logic [pll_cfg_pkg::NUM_REGS-1:0]     sel
);
  import pll_cfg_pkg::*;

  for (genvar n = 0; n < NUM_REGS; n++) begin : g_sel
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(reg_offset(n));
    assign sel[n] = (addr == OFS);
  end
endmodule

// File: rtl/pll_cfg_hwreg.sv
module pll_cfg_hwreg #(
  parameter int unsigned     WIDTH  = 16,
  parameter logic [WIDTH-1:0] RST   = '0,
  parameter logic [WIDTH-1:0] IMPL  = '1,
  parameter bit              MASKED = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [pll_cfg_pkg::DATA_W-1:0] wdata,
  output logic [WIDTH-1:0]               q
);
  import pll_cfg_pkg::*;

  logic [WIDTH-1:0] nxt;

  if (MASKED) begin : g_masked
    // per-bit enables from the upper half-word
    logic [WIDTH-1:0] en;
    assign en  = wdata[HALF_W +: WIDTH] & IMPL;
    assign nxt = (q & ~en) | (wdata[WIDTH-1:0] & en);
    if (WIDTH < HALF_W) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^{wdata[DATA_W-1:HALF_W+WIDTH], wdata[HALF_W-1:WIDTH]};
    end
  end else begin : g_plain
    assign nxt = wdata[WIDTH-1:0] & IMPL;
    if (WIDTH < DATA_W) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wdata[DATA_W-1:WIDTH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST & IMPL;
    else if (wr_en) q <= nxt;
  end
endmodule

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  if (STAGES == 0) begin : g_bypass
    assign sync_out = async_in;
  end else begin : g_chain
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else begin
        pipe[0] <= async_in;
        for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
    end
    assign sync_out = pipe[STAGES-1];
  end
endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank #(
  parameter int unsigned ADDR_W           = 8,
  parameter int unsigned LOCK_SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic              pll_lock,
  output logic [11:0]       fb_div,
  output logic [2:0]        post_div1,
  output logic [5:0]        ref_div,
  output logic [2:0]        post_div2,
  output logic              frac_bypass,
  output logic              power_down,
  output logic [23:0]       frac_val
);
  import pll_cfg_pkg::*;

  logic [NUM_REGS-1:0] sel;
  logic [NUM_REGS-1:0] wr_hit;
  logic [HALF_W-1:0]   r0_q;
  logic [HALF_W-1:0]   r1_q;
  logic [FRAC_W-1:0]   r2_q;
  logic                lock_q;

  pll_cfg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_hit = sel & {NUM_REGS{bus_we}};

  pll_cfg_hwreg #(.WIDTH(HALF_W), .RST(R0_RST), .IMPL(R0_IMPL), .MASKED(1'b1)) u_reg0 (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_hit[0]), .wdata (bus_wdata), .q (r0_q)
  );

  pll_cfg_hwreg #(.WIDTH(HALF_W), .RST(R1_RST), .IMPL(R1_IMPL), .MASKED(1'b1)) u_reg1 (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_hit[1]), .wdata (bus_wdata), .q (r1_q)
  );

  pll_cfg_hwreg #(.WIDTH(FRAC_W), .RST(R2_RST), .IMPL(R2_IMPL), .MASKED(1'b0)) u_reg2 (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_hit[2]), .wdata (bus_wdata), .q (r2_q)
  );

  pll_lock_sync #(.STAGES(LOCK_SYNC_STAGES)) u_lock (
    .clk (clk), .rst_n (rst_n), .async_in (pll_lock), .sync_out (lock_q)
  );

  // field decode
  assign fb_div      = r0_q[FB_LSB  +: FB_W];
  assign post_div1   = r0_q[PD1_LSB +: PD_W];
  assign ref_div     = r1_q[REF_LSB +: REF_W];
  assign post_div2   = r1_q[PD2_LSB +: PD_W];
  assign frac_bypass = r1_q[BYP_BIT];
  assign power_down  = r1_q[PWR_BIT];
  assign frac_val    = r2_q;

  // read path
  logic [HALF_W-1:0] r1_view;
  always_comb begin
    r1_view = r1_q;
    r1_view[LOCK_BIT] = lock_q;
  end

  always_comb begin
    unique case (1'b1)
      sel[0]:  bus_rdata = {{HALF_W{1'b0}}, r0_q};
      sel[1]:  bus_rdata = {{HALF_W{1'b0}}, r1_view};
      sel[2]:  bus_rdata = {{(DATA_W-FRAC_W){1'b0}}, r2_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pll_cfg_bank_chk.sv
module pll_cfg_bank_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input logic              lock_q,
  input logic [11:0]       fb_div,
  input logic [2:0]        post_div1,
  input logic [5:0]        ref_div,
  input logic [2:0]        post_div2,
  input logic              frac_bypass,
  input logic              power_down,
  input logic [23:0]       frac_val
);
  logic a0, a1, a2, undef;
  assign a0 = (bus_addr == ADDR_W'(0));
  assign a1 = (bus_addr == ADDR_W'(4));
  assign a2 = (bus_addr == ADDR_W'(8));
  assign undef = !(a0 || a1 || a2);

  AST_R0_NOMASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a0 && bus_wdata[31:16] == 16'h0) |=> ($stable(fb_div) && $stable(post_div1))); // R2

  AST_R1_NOMASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a1 && bus_wdata[31:16] == 16'h0) |=> ($stable(ref_div) && $stable(post_div2) && $stable(frac_bypass))); // R3

  AST_PWR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a1 && bus_wdata[29]) |=> (power_down == $past(bus_wdata[13]))); // R4

  AST_FRAC_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    a2 |-> (bus_rdata[31:24] == 8'h0)); // R5

  AST_LOCK_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    a1 |-> (bus_rdata[10] == lock_q)); // R6

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (a0 || a1) |-> (bus_rdata[31:16] == 16'h0)); // R7

  AST_UNDEF_READ: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (bus_rdata == 32'h0)); // R8

  AST_UNDEF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && undef) |=> ($stable(fb_div) && $stable(post_div1) && $stable(ref_div) &&
                           $stable(post_div2) && $stable(frac_bypass) && $stable(power_down) &&
                           $stable(frac_val))); // R8
endmodule

bind pll_cfg_bank pll_cfg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
  .bus_we (bus_we), .bus_rdata (bus_rdata), .lock_q (lock_q),
  .fb_div (fb_div), .post_div1 (post_div1), .ref_div (ref_div),
  .post_div2 (post_div2), .frac_bypass (frac_bypass), .power_down (power_down),
  .frac_val (frac_val)
);

// File: tb/pll_cfg_bank_bench.sv
module pll_cfg_bank_bench;
  localparam int unsigned AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        pll_lock = 1'b0;
  logic [11:0] fb_div;
  logic [2:0]  post_div1;
  logic [5:0]  ref_div;
  logic [2:0]  post_div2;
  logic        frac_bypass;
  logic        power_down;
  logic [23:0] frac_val;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pll_cfg_bank #(.ADDR_W(AW), .LOCK_SYNC_STAGES(2)) u_pll_cfg_bank (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_we (bus_we), .bus_rdata (bus_rdata), .pll_lock (pll_lock),
    .fb_div (fb_div), .post_div1 (post_div1), .ref_div (ref_div),
    .post_div2 (post_div2), .frac_bypass (frac_bypass), .power_down (power_down),
    .frac_val (frac_val)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(8'h00, d); check("R1 reg0 reset", d, 32'h0000_1001);
    bus_read(8'h04, d); check("R1 reg1 reset", d, 32'h0000_3041);
    bus_read(8'h08, d); check("R1 reg2 reset", d, 32'h0);
    check("R4 power_down after reset", {31'b0, power_down}, 32'h1);
    check("R1 fb_div after reset", {20'b0, fb_div}, 32'h1);
  endtask

  task automatic t_reg0_masked;
    logic [31:0] d;
    bus_write(8'h00, 32'hFFFF_0ABC);
    check("R9 fb_div after full write", {20'b0, fb_div}, 32'h0ABC);
    check("R9 post_div1 after full write", {29'b0, post_div1}, 32'h0);
    bus_write(8'h00, 32'h0FFF_7123);
    bus_read(8'h00, d); check("R2 divider only mask", d, 32'h0000_0123);
    bus_write(8'h00, 32'h7000_5000);
    bus_read(8'h00, d); check("R2 post_div1 only mask", d, 32'h0000_5123);
    check("R2 post_div1 port", {29'b0, post_div1}, 32'h5);
    bus_write(8'h00, 32'h0000_FFFF);
    bus_read(8'h00, d); check("R2 empty mask keeps value", d, 32'h0000_5123);
  endtask

  task automatic t_reg1_fields;
    logic [31:0] d;
    bus_write(8'h04, 32'h35FF_04C5);
    bus_read(8'h04, d); check("R3 R6 reg1 fields, lock bit not stored", d, 32'h0000_00C5);
    check("R3 ref_div", {26'b0, ref_div}, 32'h5);
    check("R3 post_div2", {29'b0, post_div2}, 32'h3);
    check("R3 frac_bypass cleared", {31'b0, frac_bypass}, 32'h0);
    check("R4 power-up", {31'b0, power_down}, 32'h0);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    @(negedge clk); pll_lock = 1'b1;
    repeat (3) @(posedge clk);
    bus_read(8'h04, d); check("R6 lock seen", d, 32'h0000_04C5);
    @(negedge clk); pll_lock = 1'b0;
    repeat (3) @(posedge clk);
    bus_read(8'h04, d); check("R6 lock dropped", d, 32'h0000_00C5);
  endtask

  task automatic t_upper;
    logic [31:0] d;
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, d); check("R7 reg0 upper half empty", d, 32'h0000_7FFF);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, d); check("R7 R3 reg1 upper half and holes", d, 32'h0000_31FF);
    check("R4 power_down set", {31'b0, power_down}, 32'h1);
  endtask

  task automatic t_reg2;
    logic [31:0] d;
    bus_write(8'h08, 32'hDEAD_BEEF);
    bus_read(8'h08, d); check("R5 frac read", d, 32'h00AD_BEEF);
    check("R5 frac_val port", {8'b0, frac_val}, 32'h00AD_BEEF);
    bus_write(8'h08, 32'h0000_0001);
    bus_read(8'h08, d); check("R5 no mask semantics", d, 32'h0000_0001);
  endtask

  task automatic t_undef;
    logic [31:0] d;
    bus_write(8'h00, 32'hFFFF_2345);
    bus_write(8'h0C, 32'hFFFF_FFFF);
    bus_write(8'h02, 32'h0000_0000);
    bus_write(8'hFC, 32'hFFFF_0000);
    bus_read(8'h00, d); check("R8 reg0 untouched", d, 32'h0000_2345);
    bus_read(8'h04, d); check("R8 reg1 untouched", d, 32'h0000_31FF);
    bus_read(8'h08, d); check("R8 reg2 untouched", d, 32'h0000_0001);
    bus_read(8'h0C, d); check("R8 read 0x0C", d, 32'h0);
    bus_read(8'h02, d); check("R8 read misaligned", d, 32'h0);
    bus_read(8'hFC, d); check("R8 read 0xFC", d, 32'h0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    bus_write(8'h04, 32'h3FFF_0005);
    @(negedge clk);
    pll_lock = 1'b1;
    bus_addr = 8'h04; bus_wdata = 32'h25C0_21C5; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    bus_read(8'h04, d); check("R6 R3 write and lock in one cycle", d, 32'h0000_25C5);
    check("R4 power_down from same-cycle write", {31'b0, power_down}, 32'h1);
    check("R3 post_div2 from same-cycle write", {29'b0, post_div2}, 32'h7);
    @(negedge clk); pll_lock = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reg0_masked();
    t_reg1_fields();
    t_lock();
    t_upper();
    t_reg2();
    t_undef();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule